// File: doc/BRIEF.md
# Buffered Serial Transmitter with SPI Master Mode

This block is a serial peripheral whose datapath is shared between a USART and a master-only SPI engine. A 2-bit mode field picks the personality. In SPI master mode the block drives SCK and MOSI and samples MISO. Byte transfers are fed from a single-byte transmit holding register, which sits in front of the transmit shift register, so the next byte can be queued while the current one is shifting. Received bytes go into a receive holding register.

Software programs the block through a small write port with five addresses. Address 0 loads a byte to transmit. Address 1 is the status register, where writing 1 to bit 6 clears the transmit-complete flag. Address 2 is the control register: bit 6 enables the transmit-complete interrupt, bit 5 enables the data-empty interrupt, bit 4 enables the receiver and bit 3 enables the transmitter. Bits 2:0 of the control register are reserved. Address 3 is the mode register: bits 7:6 hold the mode, bit 2 selects LSB-first order, bit 1 is clock phase and bit 0 is clock polarity. Address 4 holds the half-period divider of SCK.

The status outputs are data-empty, transmit-complete and receive-complete. Two interrupt requests are gated by a global interrupt enable input. The block also provides pin-override signals for the TX and RX sides. Only the SPI master personality is built; the asynchronous and synchronous USART framing lie outside this block.

Top module: `usart_spi_master`

## Requirements
- R1: After reset, data-empty is 1. Transmit-complete, receive-complete, both overrides, both interrupt requests, SCK and MOSI are 0, and the mode is 00.
- R2: Mode values are 00 asynchronous USART, 01 synchronous USART, 10 reserved and 11 SPI master. Transfers start only in mode 11. In the other three modes a queued byte stays in the holding register (data-empty stays 0) and SCK does not toggle.
- R3: A transfer has 16 SCK edges, spaced divider+1 clock cycles apart. While idle, SCK rests at the polarity bit. With phase 0, the first bit is on MOSI before the first edge, MISO is sampled on leading edges and MOSI changes on trailing edges. With phase 1, MOSI changes on leading edges and MISO is sampled on trailing edges.
- R4: Mode register bit 2 = 0 sends and receives MSB first. Bit 2 = 1 sends and receives LSB first.
- R5: Order, phase and polarity written in the same mode-register write that selects mode 11 apply to the first transfer after that write.
- R6: A write to address 0 is accepted only while the transmitter enable is set and the holding register is empty. Acceptance drops data-empty. Moving the byte into the shift register raises data-empty again. A write made while the holding register is full is discarded.
- R7: With the receiver enabled and the transmitter disabled, no transfer starts. Writes to address 0 are ignored, so data-empty stays 1.
- R8: Transmit-complete is set when the last bit has shifted out and no byte is waiting in the holding register. Writing 1 to status bit 6 clears it.
- R9: After the transmitter enable is cleared, the TX override and the transmitter stay active until both the shift register and the holding register are empty. The queued byte is still sent. The override drops after that.
- R10: At the end of every transfer with the receiver enabled, the received byte is latched and receive-complete is set. A pulse on rx_read clears receive-complete.
- R11: Clearing the receiver enable flushes the receive holding register to 0, clears receive-complete and drops the RX override.
- R12: irq_txc is high only when the control-bit-6 enable, gie and transmit-complete are all 1. irq_dre is high only when the control-bit-5 enable, gie and data-empty are all 1.
- R13: Control-register bits 2:0 are reserved and have no effect. Writing them as 1 changes neither the enables nor the transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 data, 1 status, 2 control, 3 mode, 4 divider) |
| reg_wdata | input | 8 | Register write data |
| rx_read | input | 1 | Read pulse that clears receive-complete |
| gie | input | 1 | Global interrupt enable |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| tx_override | output | 1 | Transmitter owns the TX pin |
| rx_override | output | 1 | Receiver owns the RX pin |
| rx_data | output | 8 | Receive holding register |
| dre | output | 1 | Transmit holding register empty |
| txc | output | 1 | Transmit complete flag |
| rxc | output | 1 | Receive complete flag |
| irq_txc | output | 1 | Transmit-complete interrupt request |
| irq_dre | output | 1 | Data-empty interrupt request |

## Verification
The assertions assume three things about the inputs. First, phase and polarity do not change while a transfer is running. Second, the mode field does not leave 11 while a transfer is running. Third, software writes the reserved control bits in any pattern. The stimulus rewrites the mode register only between transfers: the block is idle then, or it is parked in a non-SPI mode with nothing shifting. The stimulus deliberately writes the reserved bits as 1 in half of the sweep. The bench's SPI slave model counts only the SCK edges that occur after it has been armed, and it is armed only after the idle polarity has settled. This keeps a polarity change from being mistaken for a transfer edge.

// File: rtl/usm_pkg.sv
package usm_pkg;

  typedef enum logic [1:0] {
    MODE_ASYNC = 2'b00,
    MODE_SYNC  = 2'b01,
    MODE_RSVD  = 2'b10,
    MODE_SPI   = 2'b11
  } mode_e;

  localparam logic [2:0] ADDR_DATA = 3'd0;
  localparam logic [2:0] ADDR_STAT = 3'd1;
  localparam logic [2:0] ADDR_CTRL = 3'd2;
  localparam logic [2:0] ADDR_MODE = 3'd3;
  localparam logic [2:0] ADDR_DIV  = 3'd4;

  localparam int BIT_TXC_IE = 6;
  localparam int BIT_DRE_IE = 5;
  localparam int BIT_RX_EN  = 4;
  localparam int BIT_TX_EN  = 3;
  localparam int BIT_TXC    = 6;
  localparam int BIT_LSB    = 2;
  localparam int BIT_CPHA   = 1;
  localparam int BIT_CPOL   = 0;

endpackage

// File: rtl/usm_baud.sv
module usm_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run || cnt_q == div) cnt_d = '0;
    else                      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == div);

endmodule

// File: rtl/usm_spi_eng.sv
module usm_spi_eng #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] load,
  input  logic              lsb_first,
  input  logic              cpha,
  input  logic              cpol,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic              sck,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_byte
);

  localparam int HC_W = $clog2(2 * DATA_W);
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(2 * DATA_W - 1);

  logic              busy_q, busy_d;
  logic              sck_q, sck_d;
  logic              mosi_q, mosi_d;
  logic [HC_W-1:0]   hc_q, hc_d;
  logic [DATA_W-1:0] sr_q, sr_d;
  logic [DATA_W-1:0] rx_q, rx_nxt;
  logic              lead, edge_ev, shift_ev, sample_ev;

  function automatic logic out_bit(input logic [DATA_W-1:0] v, input logic lsb);
    return lsb ? v[0] : v[DATA_W-1];
  endfunction

  function automatic logic [DATA_W-1:0] adv(input logic [DATA_W-1:0] v, input logic lsb);
    return lsb ? (v >> 1) : (v << 1);
  endfunction

  assign lead      = ~hc_q[0];
  assign edge_ev   = busy_q && tick;
  assign shift_ev  = edge_ev && (lead == cpha);
  assign sample_ev = edge_ev && (lead != cpha);
  assign done      = edge_ev && (hc_q == HC_LAST);

  always_comb begin
    rx_nxt = rx_q;
    if (sample_ev) begin
      if (lsb_first) rx_nxt = {miso, rx_q[DATA_W-1:1]};
      else           rx_nxt = {rx_q[DATA_W-2:0], miso};
    end
  end

  always_comb begin
    busy_d = busy_q;
    sck_d  = sck_q;
    mosi_d = mosi_q;
    hc_d   = hc_q;
    sr_d   = sr_q;
    if (edge_ev) begin
      sck_d = ~sck_q;
      hc_d  = hc_q + 1'b1;
      if (shift_ev) begin
        mosi_d = out_bit(sr_q, lsb_first);
        sr_d   = adv(sr_q, lsb_first);
      end
      if (done) busy_d = 1'b0;
    end
    if (start) begin
      busy_d = 1'b1;
      hc_d   = '0;
      sck_d  = cpol;
      if (!cpha) begin
        mosi_d = out_bit(load, lsb_first);
        sr_d   = adv(load, lsb_first);
      end else begin
        sr_d   = load;
      end
    end else if (!busy_q) begin
      sck_d = cpol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
      hc_q   <= '0;
      sr_q   <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      sck_q  <= sck_d;
      mosi_q <= mosi_d;
      hc_q   <= hc_d;
      sr_q   <= sr_d;
      rx_q   <= rx_nxt;
    end
  end

  assign busy    = busy_q;
  assign sck     = sck_q;
  assign mosi    = mosi_q;
  assign rx_byte = rx_nxt;

  // R3: a transfer begins with SCK at its idle level
  assert_start_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (sck_q == cpol));

  // R3: a transfer ends with SCK back at its idle level
  assert_end_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (sck_q == cpol));

endmodule

// File: rtl/usart_spi_master.sv
module usart_spi_master #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              rx_read,
  input  logic              gie,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              tx_override,
  output logic              rx_override,
  output logic [DATA_W-1:0] rx_data,
  output logic              dre,
  output logic              txc,
  output logic              rxc,
  output logic              irq_txc,
  output logic              irq_dre
);

  import usm_pkg::*;

  logic [DATA_W-1:0] hold_q, hold_d;
  logic              full_q, full_d;
  logic              tx_req_q, tx_req_d;
  logic              tx_eff_q, tx_eff_d;
  logic              rx_en_q, rx_en_d;
  logic              txc_ie_q, txc_ie_d;
  logic              dre_ie_q, dre_ie_d;
  mode_e             mode_q, mode_d;
  logic              lsb_q, lsb_d;
  logic              cpha_q, cpha_d;
  logic              cpol_q, cpol_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              txc_q, txc_d;
  logic              rxc_q, rxc_d;
  logic [DATA_W-1:0] rxb_q, rxb_d;

  logic              wr_data, wr_stat, wr_ctrl, wr_mode, wr_div;
  logic              spi_on, eng_start, eng_busy, eng_done, tick;
  logic [DATA_W-1:0] eng_rx;

  assign wr_data = reg_wr && (reg_addr == ADDR_DATA);
  assign wr_stat = reg_wr && (reg_addr == ADDR_STAT);
  assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_mode = reg_wr && (reg_addr == ADDR_MODE);
  assign wr_div  = reg_wr && (reg_addr == ADDR_DIV);

  assign spi_on    = (mode_q == MODE_SPI);
  assign eng_start = spi_on && tx_eff_q && full_q && (!eng_busy || eng_done);

  usm_baud #(.DIV_W(DIV_W)) i_baud (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (eng_busy),
    .div  (div_q),
    .tick (tick)
  );

  usm_spi_eng #(.DATA_W(DATA_W)) i_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (eng_start),
    .load     (hold_q),
    .lsb_first(lsb_q),
    .cpha     (cpha_q),
    .cpol     (cpol_q),
    .tick     (tick),
    .miso     (miso),
    .busy     (eng_busy),
    .done     (eng_done),
    .sck      (sck),
    .mosi     (mosi),
    .rx_byte  (eng_rx)
  );

  // configuration registers
  always_comb begin
    tx_req_d = tx_req_q;
    rx_en_d  = rx_en_q;
    txc_ie_d = txc_ie_q;
    dre_ie_d = dre_ie_q;
    mode_d   = mode_q;
    lsb_d    = lsb_q;
    cpha_d   = cpha_q;
    cpol_d   = cpol_q;
    div_d    = div_q;
    if (wr_ctrl) begin
      txc_ie_d = reg_wdata[BIT_TXC_IE];
      dre_ie_d = reg_wdata[BIT_DRE_IE];
      rx_en_d  = reg_wdata[BIT_RX_EN];
      tx_req_d = reg_wdata[BIT_TX_EN];
    end
    if (wr_mode) begin
      mode_d = mode_e'(reg_wdata[7:6]);
      lsb_d  = reg_wdata[BIT_LSB];
      cpha_d = reg_wdata[BIT_CPHA];
      cpol_d = reg_wdata[BIT_CPOL];
    end
    if (wr_div) div_d = DIV_W'(reg_wdata);
  end

  // transmit holding register and effective transmitter enable
  always_comb begin
    hold_d   = hold_q;
    full_d   = full_q;
    tx_eff_d = tx_eff_q;
    if (wr_data && tx_req_q && !full_q) begin
      hold_d = DATA_W'(reg_wdata);
      full_d = 1'b1;
    end else if (eng_start) begin
      full_d = 1'b0;
    end
    if (wr_ctrl && reg_wdata[BIT_TX_EN])               tx_eff_d = 1'b1;
    else if (!tx_req_q && !full_q && !eng_busy)        tx_eff_d = 1'b0;
  end

  // flags and receive holding register
  always_comb begin
    txc_d = txc_q;
    rxc_d = rxc_q;
    rxb_d = rxb_q;
    if (wr_stat && reg_wdata[BIT_TXC]) txc_d = 1'b0;
    if (eng_done && !full_q)           txc_d = 1'b1;
    if (eng_done && rx_en_q) begin
      rxb_d = eng_rx;
      rxc_d = 1'b1;
    end else if (rx_read) begin
      rxc_d = 1'b0;
    end
    if (!rx_en_q) begin
      rxb_d = '0;
      rxc_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      full_q   <= 1'b0;
      tx_req_q <= 1'b0;
      tx_eff_q <= 1'b0;
      rx_en_q  <= 1'b0;
      txc_ie_q <= 1'b0;
      dre_ie_q <= 1'b0;
      mode_q   <= MODE_ASYNC;
      lsb_q    <= 1'b0;
      cpha_q   <= 1'b0;
      cpol_q   <= 1'b0;
      div_q    <= '0;
      txc_q    <= 1'b0;
      rxc_q    <= 1'b0;
      rxb_q    <= '0;
    end else begin
      hold_q   <= hold_d;
      full_q   <= full_d;
      tx_req_q <= tx_req_d;
      tx_eff_q <= tx_eff_d;
      rx_en_q  <= rx_en_d;
      txc_ie_q <= txc_ie_d;
      dre_ie_q <= dre_ie_d;
      mode_q   <= mode_d;
      lsb_q    <= lsb_d;
      cpha_q   <= cpha_d;
      cpol_q   <= cpol_d;
      div_q    <= div_d;
      txc_q    <= txc_d;
      rxc_q    <= rxc_d;
      rxb_q    <= rxb_d;
    end
  end

  assign tx_override = tx_eff_q;
  assign rx_override = rx_en_q;
  assign rx_data     = rxb_q;
  assign dre         = ~full_q;
  assign txc         = txc_q;
  assign rxc         = rxc_q;
  assign irq_txc     = txc_ie_q && gie && txc_q;
  assign irq_dre     = dre_ie_q && gie && ~full_q;

  // R2: the shift engine only starts while SPI master mode is selected
  assert_start_spi_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_busy) |-> $past(mode_q == MODE_SPI));

  // R9: the TX override drops only once both transmit stages are empty
  assert_drain_before_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_override) |-> (!full_q && !eng_busy));

  // R6: a write into a full holding register leaves its contents alone
  assert_full_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && full_q && !eng_start) |=> $stable(hold_q));

  // R8: transmit-complete only rises at the end of a transfer
  assert_txc_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txc_q) |-> $past(eng_done));

  // R10: receive-complete only rises at the end of a transfer with the receiver on
  assert_rxc_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxc_q) |-> $past(eng_done && rx_en_q));

endmodule

// File: tb/test_usart_spi_master.sv
module test_usart_spi_master;

  logic       clk;
  logic       rst_n;
  logic       reg_wr;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       rx_read;
  logic       gie;
  logic       miso;
  logic       sck, mosi, tx_override, rx_override, dre, txc, rxc, irq_txc, irq_dre;
  logic [7:0] rx_data;

  int n_checks = 0;
  int n_err    = 0;

  usart_spi_master i_usart_spi_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rx_read(rx_read), .gie(gie), .miso(miso),
    .sck(sck), .mosi(mosi), .tx_override(tx_override), .rx_override(rx_override),
    .rx_data(rx_data), .dre(dre), .txc(txc), .rxc(rxc),
    .irq_txc(irq_txc), .irq_dre(irq_dre)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // SPI slave model
  logic       armed;
  logic       sck_prev;
  logic       cfg_lsb, cfg_cpha;
  logic [7:0] slv_arr [8];
  logic [7:0] cap_arr [8];
  logic [7:0] cur;
  int         xfer_n, edges, cyc, t_first, gap, last_gap, k, idx;

  function automatic logic bit_of(input logic [7:0] b, input int i, input logic lsb);
    return lsb ? b[i] : b[7-i];
  endfunction

  initial begin
    armed = 1'b0; sck_prev = 1'b0; cfg_lsb = 1'b0; cfg_cpha = 1'b0;
    xfer_n = 0; edges = 0; cyc = 0; gap = 0; last_gap = 0; t_first = 0;
    cur = '0; miso = 1'b0;
    for (int i = 0; i < 8; i++) begin slv_arr[i] = '0; cap_arr[i] = '0; end
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (armed) begin
      if (sck !== sck_prev) begin
        edges = edges + 1;
        if (edges == 1) t_first = cyc;
        if (edges == 2) gap = cyc - t_first;
        if ((!cfg_cpha && edges % 2 == 1) || (cfg_cpha && edges % 2 == 0)) begin
          k = cfg_cpha ? edges / 2 - 1 : (edges - 1) / 2;
          if (cfg_lsb) cur[k] = mosi; else cur[7-k] = mosi;
        end
        if (edges == 16) begin
          cap_arr[xfer_n % 8] = cur;
          last_gap = gap;
          xfer_n = xfer_n + 1;
          edges = 0;
        end
      end
      sck_prev = sck;
    end
    idx = cfg_cpha ? ((edges == 0) ? 0 : (edges - 1) / 2) : edges / 2;
    if (idx > 7) idx = 7;
    miso = bit_of(slv_arr[xfer_n % 8], idx, cfg_lsb);
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic arm();
    sck_prev = sck; edges = 0; armed = 1'b1;
  endtask

  task automatic wait_txc(input int lim);
    for (int i = 0; i < lim && !txc; i++) step();
    step();
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] sl, input int dv);
    int n0;
    n0 = xfer_n;
    slv_arr[n0 % 8] = sl;
    wr(3'd0, tx);
    wait_txc(2000);
    chk("R3 sixteen edges", 32'(xfer_n), 32'(n0 + 1));
    chk("R4 mosi byte", {24'd0, cap_arr[n0 % 8]}, {24'd0, tx});
    chk("R3 half period", 32'(last_gap), 32'(dv + 1));
    chk("R10 rx byte", {24'd0, rx_data}, {24'd0, sl});
    chk("R10 rxc set", {31'd0, rxc}, 32'd1);
    chk("R8 txc set", {31'd0, txc}, 32'd1);
    wr(3'd1, 8'h40);
    chk("R8 txc cleared", {31'd0, txc}, 32'd0);
    rx_read = 1'b1; step(); rx_read = 1'b0;
    chk("R10 rxc cleared", {31'd0, rxc}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog (R3): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    int n0;
    logic [7:0] b;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; rx_read = 1'b0; gie = 1'b0;
    repeat (4) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk("R1 dre", {31'd0, dre}, 32'd1);
    chk("R1 txc", {31'd0, txc}, 32'd0);
    chk("R1 rxc", {31'd0, rxc}, 32'd0);
    chk("R1 overrides", {30'd0, tx_override, rx_override}, 32'd0);
    chk("R1 irqs", {30'd0, irq_txc, irq_dre}, 32'd0);
    chk("R1 sck mosi", {30'd0, sck, mosi}, 32'd0);

    // R3 R4 R5 R13 sweep over SPI modes, bit order and divider
    for (int m = 0; m < 4; m++) begin
      for (int o = 0; o < 2; o++) begin
        for (int d = 0; d < 2; d++) begin
          armed = 1'b0;
          cfg_cpha = m[0]; cfg_lsb = o[0];
          wr(3'd4, (d != 0) ? 8'd2 : 8'd0);
          wr(3'd3, {2'b11, 3'b000, o[0], m[0], m[1]});
          step();
          chk("R5 idle sck equals polarity", {31'd0, sck}, {31'd0, m[1]});
          arm();
          wr(3'd2, (d != 0) ? 8'h1F : 8'h18);
          chk("R13 reserved bits ignored", {30'd0, tx_override, rx_override}, 32'd3);
          b = 8'(37 * (m * 4 + o * 2 + d) + 1);
          xfer(b, b ^ 8'h3C, (d != 0) ? 2 : 0);
          xfer(~b, b ^ 8'hC5, (d != 0) ? 2 : 0);
        end
      end
    end

    // R2 non-SPI modes hold the queued byte
    armed = 1'b0;
    wr(3'd4, 8'd3);
    wr(3'd3, 8'h00);
    step();
    cfg_lsb = 1'b1; cfg_cpha = 1'b0;
    arm();
    wr(3'd2, 8'h18);
    n0 = xfer_n;
    slv_arr[n0 % 8] = 8'h96;
    wr(3'd0, 8'hC3);
    for (int mv = 0; mv < 3; mv++) begin
      wr(3'd3, {mv[1:0], 6'b000000});
      repeat (40) step();
      chk("R2 byte held in non-SPI mode", {31'd0, dre}, 32'd0);
      chk("R2 no transfer in non-SPI mode", 32'(xfer_n), 32'(n0));
      chk("R2 no sck edges", 32'(edges), 32'd0);
    end
    armed = 1'b0;
    wr(3'd3, 8'hC5);
    step();
    arm();
    wait_txc(2000);
    chk("R5 first transfer uses new settings", {24'd0, cap_arr[n0 % 8]}, 32'h0000_00C3);
    chk("R2 transfer once SPI selected", 32'(xfer_n), 32'(n0 + 1));
    chk("R10 rx in lsb order", {24'd0, rx_data}, 32'h0000_0096);
    wr(3'd1, 8'h40);

    // R7 receiver alone starts nothing
    wr(3'd2, 8'h10);
    repeat (3) step();
    chk("R7 tx override released", {31'd0, tx_override}, 32'd0);
    chk("R7 rx override held", {31'd0, rx_override}, 32'd1);
    n0 = xfer_n;
    wr(3'd0, 8'h77);
    repeat (40) step();
    chk("R7 data write ignored", {31'd0, dre}, 32'd1);
    chk("R7 no transfer", 32'(xfer_n), 32'(n0));

    // R6 R9 buffered transmit, full-write discard, draining disable
    armed = 1'b0;
    cfg_lsb = 1'b0; cfg_cpha = 1'b0;
    wr(3'd4, 8'd7);
    wr(3'd3, 8'hC0);
    step();
    arm();
    wr(3'd2, 8'h18);
    n0 = xfer_n;
    slv_arr[n0 % 8] = 8'h11;
    slv_arr[(n0 + 1) % 8] = 8'h22;
    wr(3'd0, 8'hA1);
    chk("R6 write accepted", {31'd0, dre}, 32'd0);
    step();
    chk("R6 byte moved to shifter", {31'd0, dre}, 32'd1);
    wr(3'd0, 8'hB2);
    chk("R6 second byte queued", {31'd0, dre}, 32'd0);
    wr(3'd0, 8'hCC);
    wr(3'd2, 8'h10);
    step();
    chk("R9 override held while draining", {31'd0, tx_override}, 32'd1);
    wait_txc(3000);
    chk("R9 two transfers drained", 32'(xfer_n), 32'(n0 + 2));
    chk("R9 first byte sent", {24'd0, cap_arr[n0 % 8]}, 32'h0000_00A1);
    chk("R6 queued byte sent", {24'd0, cap_arr[(n0 + 1) % 8]}, 32'h0000_00B2);
    repeat (3) step();
    chk("R9 override released", {31'd0, tx_override}, 32'd0);
    repeat (50) step();
    chk("R6 full write discarded", 32'(xfer_n), 32'(n0 + 2));

    // R11 receiver disable flushes
    chk("R11 rxc before flush", {31'd0, rxc}, 32'd1);
    wr(3'd2, 8'h00);
    step();
    chk("R11 rx buffer flushed", {24'd0, rx_data}, 32'd0);
    chk("R11 rxc flushed", {31'd0, rxc}, 32'd0);
    chk("R11 rx override off", {31'd0, rx_override}, 32'd0);

    // R12 interrupt gating (txc still set from drain test)
    gie = 1'b0;
    wr(3'd2, 8'h60);
    chk("R12 gie low masks", {30'd0, irq_txc, irq_dre}, 32'd0);
    gie = 1'b1;
    step();
    chk("R12 both requests", {30'd0, irq_txc, irq_dre}, 32'd3);
    wr(3'd1, 8'h40);
    chk("R12 txc request follows flag", {31'd0, irq_txc}, 32'd0);
    wr(3'd2, 8'h40);
    chk("R12 dre enable off", {31'd0, irq_dre}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule